// File: doc/BRIEF.md
# Masked Low-Bit Pattern Unit

This unit produces one result from a family of low-bit manipulation results on a 64-bit operand. Examples are clearing the lowest set bit, isolating it, building a mask up to it, and filling trailing bits. Every result has the shape `A(x) op C(x)`. A 5-bit mode field selects the first term, the combining operator and the second term. The operation applies only inside a predicate mask, which comes from a second operand. A separate flag says that the mask source index is zero; in that case the mask is all ones. A keep flag decides what happens to operand bits outside the mask: they pass through unchanged or they are cleared.

The unit is combinational. A parameter can add an output register stage that is qualified by a valid strobe. It has no carry, overflow or status output. One mode encoding is reserved: it raises an illegal-instruction flag instead of producing a result.

Top module: `bmask_unit`

## Requirements
- R1: When `mask_zero_i` is 1, the effective mask `m` is all ones and `mask_i` is ignored. Otherwise `m = mask_i`. The working value is `x = operand_i & m`.
- R2: When `keep_i` is 1 and the mode is legal, result bits where `m` is 0 equal the same bits of `operand_i`.
- R3: When `keep_i` is 0, result bits where `m` is 0 are 0.
- R4: `mode_i[1:0]` selects the operator: 00 OR, 01 AND, 10 XOR. Result bits inside `m` are `(A op C) & m`.
- R5: `mode_i[3:2]` selects the second term C: 00 `x+1`, 01 `x-1`, 10 `~(x+1)`, 11 `(~x)+1`. All arithmetic wraps modulo 2^64, so `0-1` gives all ones and all ones `+1` gives 0.
- R6: `mode_i[4]` selects the first term A: 0 gives `x`, 1 gives `~x`.
- R7: `mode_i[1:0] = 11` sets `illegal_o` to 1 and forces `result_o` to 0. Every other mode sets `illegal_o` to 0.
- R8: With `OUT_REG=1`, `valid_o` is `valid_i` delayed by one cycle. Each accepted input shows its result one cycle later. `result_o` and `illegal_o` hold their values while `valid_i` is 0.
- R9: After reset, `valid_o`, `result_o` and `illegal_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input operands valid |
| operand_i | input | 64 | Source operand |
| mask_i | input | 64 | Predicate mask operand |
| mask_zero_i | input | 1 | Mask source index is zero, so the mask is all ones |
| mode_i | input | 5 | Term and operator select |
| keep_i | input | 1 | Keep outside-mask operand bits (1) or clear them (0) |
| valid_o | output | 1 | Result valid |
| result_o | output | 64 | Result |
| illegal_o | output | 1 | Reserved mode was used |

## Verification
The assertions check on every valid cycle:
- the illegal flag against the mode;
- the zero result for a reserved mode;
- the handling of outside-mask bits under both keep settings;
- the hold of the registered output while no input is valid.

The arithmetic itself can only be shown by the bench scenarios. These cover the operator and term encodings, the wrap at 0 and at all ones, the lowest-set-bit identities, and random operands compared against a reference model.

// File: rtl/bmask_pkg.sv
package bmask_pkg;
  typedef enum logic [1:0] {OP_OR = 2'b00, OP_AND = 2'b01, OP_XOR = 2'b10, OP_RSV = 2'b11} op_e;
  typedef enum logic [1:0] {T_INC = 2'b00, T_DEC = 2'b01, T_NINC = 2'b10, T_NEG = 2'b11} term_e;
endpackage

// File: rtl/bmask_term.sv
module bmask_term
  import bmask_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] x_i,
  input  term_e             sel_i,
  output logic [DATA_W-1:0] term_o
);
  localparam logic [DATA_W-1:0] One = DATA_W'(1);

  logic [DATA_W-1:0] inc;
  assign inc = x_i + One;

  always_comb begin
    unique case (sel_i)
      T_INC:   term_o = inc;
      T_DEC:   term_o = x_i - One;
      T_NINC:  term_o = ~inc;
      default: term_o = (~x_i) + One;
    endcase
  end
endmodule

// File: rtl/bmask_core.sv
module bmask_core
  import bmask_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int MODE_W = 5
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic              mask_zero_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              keep_i,
  output logic [DATA_W-1:0] result_o,
  output logic              illegal_o
);
  logic [DATA_W-1:0] m, x, a, c, comb, outside;
  op_e op;

  assign m  = mask_zero_i ? '1 : mask_i;
  assign x  = operand_i & m;
  assign a  = mode_i[4] ? ~x : x;
  assign op = op_e'(mode_i[1:0]);

  bmask_term #(.DATA_W(DATA_W)) u_term (
    .x_i   (x),
    .sel_i (term_e'(mode_i[3:2])),
    .term_o(c)
  );

  always_comb begin
    unique case (op)
      OP_OR:   comb = a | c;
      OP_AND:  comb = a & c;
      OP_XOR:  comb = a ^ c;
      default: comb = '0;
    endcase
  end

  assign outside   = keep_i ? (operand_i & ~m) : '0;
  assign illegal_o = (op == OP_RSV);
  assign result_o  = illegal_o ? '0 : ((comb & m) | outside);
endmodule

// File: rtl/bmask_unit.sv
module bmask_unit #(
  parameter int DATA_W  = 64,
  parameter int MODE_W  = 5,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic              mask_zero_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              keep_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              illegal_o
);
  logic [DATA_W-1:0] res_d;
  logic              ill_d;

  bmask_core #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_core (
    .operand_i  (operand_i),
    .mask_i     (mask_i),
    .mask_zero_i(mask_zero_i),
    .mode_i     (mode_i),
    .keep_i     (keep_i),
    .result_o   (res_d),
    .illegal_o  (ill_d)
  );

  if (OUT_REG) begin : g_reg
    logic              vld_q;
    logic [DATA_W-1:0] res_q;
    logic              ill_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        res_q <= '0;
        ill_q <= 1'b0;
      end else begin
        vld_q <= valid_i;
        if (valid_i) begin
          res_q <= res_d;
          ill_q <= ill_d;
        end
      end
    end
    assign valid_o   = vld_q;
    assign result_o  = res_q;
    assign illegal_o = ill_q;
  end else begin : g_comb
    assign valid_o   = valid_i;
    assign result_o  = res_d;
    assign illegal_o = ill_d;
  end
endmodule

// File: rtl/bmask_unit_chk.sv
module bmask_unit_chk #(
  parameter int DATA_W  = 64,
  parameter int MODE_W  = 5,
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] operand_i,
  input logic [DATA_W-1:0] mask_i,
  input logic              mask_zero_i,
  input logic [MODE_W-1:0] mode_i,
  input logic              keep_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              illegal_o
);
  logic [DATA_W-1:0] s_ra, s_m;
  logic [MODE_W-1:0] s_mode;
  logic              s_keep;

  if (OUT_REG) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s_ra <= '0; s_m <= '1; s_mode <= '0; s_keep <= 1'b0;
      end else if (valid_i) begin
        s_ra   <= operand_i;
        s_m    <= mask_zero_i ? '1 : mask_i;
        s_mode <= mode_i;
        s_keep <= keep_i;
      end
    end
    // R8
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> $stable(result_o) && $stable(illegal_o));
    // R8
    valid_dly_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);
  end else begin : g_pass
    assign s_ra   = operand_i;
    assign s_m    = mask_zero_i ? '1 : mask_i;
    assign s_mode = mode_i;
    assign s_keep = keep_i;
  end

  // R7
  illegal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> illegal_o == (s_mode[1:0] == 2'b11));
  // R7
  illegal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && illegal_o |-> result_o == '0);
  // R2
  keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && s_keep && !illegal_o |-> (result_o & ~s_m) == (s_ra & ~s_m));
  // R3
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !s_keep |-> (result_o & ~s_m) == '0);
endmodule

bind bmask_unit bmask_unit_chk #(.DATA_W(DATA_W), .MODE_W(MODE_W), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/sim_bmask_unit.sv
`timescale 1ns/1ps
module sim_bmask_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] operand_i = '0, mask_i = '0;
  logic        mask_zero_i = 1'b1;
  logic [4:0]  mode_i = '0;
  logic        keep_i = 1'b0;
  logic        valid_o, illegal_o;
  logic [63:0] result_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  bmask_unit u0 (.*);

  function automatic logic [64:0] ref_calc(logic [63:0] ra, logic [63:0] mk, logic mz,
                                           logic [4:0] md, logic kp);
    logic [63:0] m, x, a, c, r;
    m = mz ? '1 : mk;
    x = ra & m;
    a = md[4] ? ~x : x;
    case (md[3:2])
      2'd0: c = x + 64'd1;
      2'd1: c = x - 64'd1;
      2'd2: c = ~(x + 64'd1);
      default: c = ~x + 64'd1;
    endcase
    case (md[1:0])
      2'd0: r = a | c;
      2'd1: r = a & c;
      2'd2: r = a ^ c;
      default: return {1'b1, 64'd0};
    endcase
    return {1'b0, (r & m) | (kp ? (ra & ~m) : 64'd0)};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(logic [63:0] ra, logic [63:0] mk, logic mz, logic [4:0] md, logic kp);
    @(negedge clk_i);
    operand_i = ra; mask_i = mk; mask_zero_i = mz; mode_i = md; keep_i = kp; valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic exp_run(string req, logic [63:0] ra, logic [63:0] mk, logic mz,
                         logic [4:0] md, logic kp, logic [63:0] exp);
    logic [64:0] r;
    run(ra, mk, mz, md, kp);
    r = ref_calc(ra, mk, mz, md, kp);
    chk(req, result_o, exp);
    chk(req, result_o, r[63:0]);
    chk(req, {63'd0, illegal_o}, {63'd0, r[64]});
    chk(req, {63'd0, valid_o}, 64'd1);
  endtask

  task automatic t_reset;
    chk("R9 valid", {63'd0, valid_o}, 64'd0);
    chk("R9 result", result_o, 64'd0);
    chk("R9 illegal", {63'd0, illegal_o}, 64'd0);
  endtask

  task automatic t_identities;
    logic [63:0] v = 64'h00F0_0000_0000_0A00;
    exp_run("R4 clear lowest", v, '0, 1'b1, 5'b00101, 1'b0, 64'h00F0_0000_0000_0800);
    exp_run("R5 isolate", v, '0, 1'b1, 5'b01101, 1'b0, 64'h0000_0000_0000_0200);
    exp_run("R4 mask upto", v, '0, 1'b1, 5'b00110, 1'b0, 64'h0000_0000_0000_03FF);
  endtask

  task automatic t_terms;
    exp_run("R5 wrap dec", 64'd0, '0, 1'b1, 5'b00100, 1'b0, '1);
    exp_run("R5 wrap inc", '1, '0, 1'b1, 5'b00001, 1'b0, 64'd0);
    exp_run("R5 ninc", 64'h0F, '0, 1'b1, 5'b01000, 1'b0, 64'hFFFF_FFFF_FFFF_FFEF);
    exp_run("R6 inv first", 64'h0F, '0, 1'b1, 5'b10001, 1'b0, 64'h10);
  endtask

  task automatic t_mask;
    exp_run("R2 keep", 64'hDEAD_BEEF_0000_00F0, 64'h0000_0000_FFFF_FFFF, 1'b0, 5'b00101, 1'b1,
            64'hDEAD_BEEF_0000_00E0);
    exp_run("R3 clear", 64'hDEAD_BEEF_0000_00F0, 64'h0000_0000_FFFF_FFFF, 1'b0, 5'b00101, 1'b0,
            64'h0000_0000_0000_00E0);
    exp_run("R1 mask zero", 64'hDEAD_BEEF_0000_00F0, 64'd0, 1'b1, 5'b00101, 1'b0,
            64'hDEAD_BEEF_0000_00E0);
  endtask

  task automatic t_illegal;
    exp_run("R7 reserved", 64'h1234, '0, 1'b1, 5'b00011, 1'b1, 64'd0);
    exp_run("R7 reserved inv", 64'h1234, '0, 1'b1, 5'b11111, 1'b0, 64'd0);
  endtask

  task automatic t_hold;
    logic [63:0] held;
    run(64'h80, '0, 1'b1, 5'b00101, 1'b0);
    held = result_o;
    @(negedge clk_i);
    operand_i = 64'hFFFF; mode_i = 5'b00011;
    @(negedge clk_i);
    chk("R8 valid low", {63'd0, valid_o}, 64'd0);
    chk("R8 hold", result_o, held);
    chk("R8 hold illegal", {63'd0, illegal_o}, 64'd0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 200; i++) begin
      logic [63:0] ra, mk;
      logic [4:0]  md;
      logic        mz, kp;
      logic [64:0] r;
      ra = {$urandom, $urandom};
      mk = {$urandom, $urandom};
      md = 5'($urandom);
      mz = 1'($urandom);
      kp = 1'($urandom);
      if (i % 7 == 0) ra = ra & 64'hFF;
      run(ra, mk, mz, md, kp);
      r = ref_calc(ra, mk, mz, md, kp);
      chk("R4 random", result_o, r[63:0]);
      chk("R7 random", {63'd0, illegal_o}, {63'd0, r[64]});
    end
  endtask

  initial begin
    #1;
    t_reset;
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    t_identities;
    t_terms;
    t_mask;
    t_illegal;
    t_hold;
    t_random;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule